// File: doc/BRIEF.md
# Multiplier-Free QPSK Modulator

This block turns a serial bit stream into a stream of signed QPSK samples. The stream comes either from the `bit_in` pin or, when `src_int` is high, from an on-chip 7-bit pseudo-random generator. In both cases a bit is taken only on a clock where `bit_valid` is high. Accepted bits are grouped in pairs. The first bit of a pair steers the in-phase channel and the second steers the quadrature channel. Because the first bit arrives first, it is held until its partner arrives, and the two are applied together.

A phase counter walks a 64-entry signed sine table once per carrier period. The same table, read a quarter period ahead, gives the cosine. Each channel picks either its carrier or that carrier's two's-complement negation, so no multiplier is needed. The two picks are added into a sample one bit wider than the table entries.

A symbol lasts `PERIODS_PER_SYM` whole carrier periods. A completed pair waits until the next symbol boundary and only then changes the channel selects. This keeps every symbol phase-continuous and a whole number of carrier cycles long.

Top module: `qpsk_carrier_mod`

## Requirements
- R1: While reset is high, and after it until the first pair is applied, `sample_valid` is 0. During reset `sample_out` is 0. After reset both channel selects are 0, so the output is −cos − sin until the first pair takes effect.
- R2: Only bits present on clocks with `bit_valid` high are accepted. Of each accepted pair, the first bit drives the I channel and the second bit drives the Q channel.
- R3: Count clock edges from the first edge with reset low as edge 0. The sample visible after edge M has carrier phase index (M−1) mod 64 and belongs to symbol slot (M−1)/L, where L = 64·`PERIODS_PER_SYM`. A pair completed inside slot s governs all samples of slot s+1.
- R4: The I term is +cos when its bit is 1 and −cos when it is 0. The Q term is +sin when its bit is 1 and −sin when it is 0. `sample_out` is their sum. Carrier values are round(127·cos(2πp/64)) and round(127·sin(2πp/64)), each within ±1, for phase index p.
- R5: If no pair completes during a symbol slot, the next slot keeps the previous selects.
- R6: `sample_valid` rises with the first sample of the first slot that uses a received pair, and it stays high until reset.
- R7: With `src_int` high, `bit_in` is ignored. Bits come from a 7-bit shift register seeded to 0000001. The output bit is bit 6. On each accepted bit the register shifts left and takes bit6 XOR bit5 into bit 0. The register advances only on accepted bits while `src_int` is high.
- R8: `sample_out` is `SAMP_W`+1 bits wide, and its magnitude never exceeds 2·(2^(`SAMP_W`−1)−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_int | input | 1 | 1 selects the internal pseudo-random bit source |
| bit_in | input | 1 | External serial data bit |
| bit_valid | input | 1 | Bit strobe; one bit is accepted per high clock |
| sample_out | output | SAMP_W+1 | Signed modulated sample |
| sample_valid | output | 1 | High once modulated data reaches the output |

## Verification
Some properties are checked by assertions on every clock:
- the channel selects never move except at a symbol boundary;
- every boundary is followed by phase and period both being zero;
- the output magnitude stays inside the carrier sum limit;
- `sample_valid` never falls;
- the pseudo-random register never holds zero and stands still without a strobe in internal mode.

Other behaviour can only be shown by the bench's scenarios, which compare every sample against trigonometric values for the pair sent in the previous slot. These scenarios cover the I-before-Q ordering, the one-slot latency, the held slot with no pair, internal-source sequences with a misleading `bit_in`, and the exact slot in which `sample_valid` rises.

// File: rtl/qpsk_mod_pkg.sv
`timescale 1ns/1ps
package qpsk_mod_pkg;

  typedef struct packed {
    logic i_bit;
    logic q_bit;
  } iq_pair_t;

  // Rational sine approximation over one half wave; the second half is mirrored negative.
  function automatic int approx_sine(input int idx, input int depth, input int amp);
    int   half_w;
    int   j;
    int   t;
    int   d;
    int   v;
    half_w = depth / 2;
    j      = (idx >= half_w) ? idx - half_w : idx;
    t      = j * (half_w - j);
    d      = 5 * half_w * half_w - 4 * t;
    v      = (16 * amp * t + d / 2) / d;
    return (idx >= half_w) ? -v : v;
  endfunction

endpackage

// File: rtl/qpsk_lfsr.sv
`timescale 1ns/1ps
module qpsk_lfsr #(
  parameter int LFSR_W    = 7,
  parameter int LFSR_SEED = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic bit_o
);
  logic [LFSR_W-1:0] state;

  assign bit_o = state[LFSR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LFSR_W'(LFSR_SEED);
    end else if (step) begin
      state <= {state[LFSR_W-2:0], state[LFSR_W-1] ^ state[LFSR_W-2]};
    end
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R7
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state));

endmodule

// File: rtl/qpsk_bit_splitter.sv
`timescale 1ns/1ps
module qpsk_bit_splitter
  import qpsk_mod_pkg::*;
#(
  parameter int LFSR_W    = 7,
  parameter int LFSR_SEED = 1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     use_int,
  input  logic     ext_bit,
  input  logic     bit_valid,
  input  logic     consume,
  output logic     pend_v,
  output iq_pair_t pend
);
  logic gen_bit;
  logic cur_bit;
  logic second;
  logic i_hold;

  qpsk_lfsr #(.LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .step (bit_valid & use_int),
    .bit_o(gen_bit)
  );

  assign cur_bit = use_int ? gen_bit : ext_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      second <= 1'b0;
      i_hold <= 1'b0;
      pend_v <= 1'b0;
      pend   <= '0;
    end else begin
      if (consume) pend_v <= 1'b0;
      if (bit_valid) begin
        if (!second) begin
          i_hold <= cur_bit;
          second <= 1'b1;
        end else begin
          pend.i_bit <= i_hold;
          pend.q_bit <= cur_bit;
          pend_v     <= 1'b1;
          second     <= 1'b0;
        end
      end
    end
  end

  // R2
  pair_done_chk: assert property (@(posedge clk) disable iff (rst)
    bit_valid && second |=> pend_v);

endmodule

// File: rtl/qpsk_symbol_timer.sv
`timescale 1ns/1ps
module qpsk_symbol_timer #(
  parameter int PH_W            = 6,
  parameter int PERIODS_PER_SYM = 2
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            sym_end
);
  localparam int PER_W = (PERIODS_PER_SYM > 1) ? $clog2(PERIODS_PER_SYM) : 1;
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIODS_PER_SYM - 1);

  logic [PER_W-1:0] per;

  assign sym_end = (phase == '1) && (per == PER_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      per   <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (phase == '1) per <= (per == PER_LAST) ? '0 : per + 1'b1;
    end
  end

  // R3
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    sym_end |=> (phase == '0) && (per == '0));

endmodule

// File: rtl/qpsk_carrier_rom.sv
`timescale 1ns/1ps
module qpsk_carrier_rom
  import qpsk_mod_pkg::*;
#(
  parameter int PH_W   = 6,
  parameter int SAMP_W = 8
) (
  input  logic                     clk,
  input  logic [PH_W-1:0]          phase,
  output logic signed [SAMP_W-1:0] sin_q,
  output logic signed [SAMP_W-1:0] cos_q
);
  localparam int DEPTH = 1 << PH_W;
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;
  localparam logic [PH_W-1:0] QUARTER = PH_W'(DEPTH / 4);

  logic signed [SAMP_W-1:0] wave_mem [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_fill
    assign wave_mem[k] = SAMP_W'(approx_sine(k, DEPTH, AMP));
  end

  always_ff @(posedge clk) begin
    sin_q <= wave_mem[phase];
    cos_q <= wave_mem[phase + QUARTER];
  end

endmodule

// File: rtl/qpsk_carrier_mod.sv
`timescale 1ns/1ps
module qpsk_carrier_mod
  import qpsk_mod_pkg::*;
#(
  parameter int SAMP_W          = 8,
  parameter int PH_W            = 6,
  parameter int PERIODS_PER_SYM = 2,
  parameter int LFSR_W          = 7,
  parameter int LFSR_SEED       = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   src_int,
  input  logic                   bit_in,
  input  logic                   bit_valid,
  output logic signed [SAMP_W:0] sample_out,
  output logic                   sample_valid
);
  localparam int AMP = (1 << (SAMP_W - 1)) - 1;
  localparam logic signed [SAMP_W:0] OUT_LIM = (SAMP_W + 1)'(2 * AMP);

  logic [PH_W-1:0]          phase;
  logic                     sym_end;
  logic                     pend_v;
  iq_pair_t                 pend;
  iq_pair_t                 sel;
  iq_pair_t                 sel_d;
  logic                     loaded;
  logic                     loaded_d;
  logic signed [SAMP_W-1:0] sin_q;
  logic signed [SAMP_W-1:0] cos_q;
  logic signed [SAMP_W:0]   cos_x;
  logic signed [SAMP_W:0]   sin_x;
  logic signed [SAMP_W:0]   i_term;
  logic signed [SAMP_W:0]   q_term;

  qpsk_symbol_timer #(.PH_W(PH_W), .PERIODS_PER_SYM(PERIODS_PER_SYM)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .sym_end(sym_end)
  );

  qpsk_bit_splitter #(.LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED)) u_split (
    .clk      (clk),
    .rst      (rst),
    .use_int  (src_int),
    .ext_bit  (bit_in),
    .bit_valid(bit_valid),
    .consume  (sym_end),
    .pend_v   (pend_v),
    .pend     (pend)
  );

  qpsk_carrier_rom #(.PH_W(PH_W), .SAMP_W(SAMP_W)) u_rom (
    .clk  (clk),
    .phase(phase),
    .sin_q(sin_q),
    .cos_q(cos_q)
  );

  // Channel selects change only on the last clock of a symbol.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      loaded <= 1'b0;
    end else if (sym_end && pend_v) begin
      sel    <= pend;
      loaded <= 1'b1;
    end
  end

  // Delay the selects to line up with the registered table read.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d    <= '0;
      loaded_d <= 1'b0;
    end else begin
      sel_d    <= sel;
      loaded_d <= loaded;
    end
  end

  assign cos_x = {cos_q[SAMP_W-1], cos_q};
  assign sin_x = {sin_q[SAMP_W-1], sin_q};

  always_comb begin
    i_term = sel_d.i_bit ? cos_x : -cos_x;
    q_term = sel_d.q_bit ? sin_x : -sin_x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_out   <= i_term + q_term;
      sample_valid <= loaded_d;
    end
  end

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sym_end |=> $stable(sel));

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> sample_valid);

  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_out <= OUT_LIM) && (sample_out >= -OUT_LIM));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (sample_out == '0) && !sample_valid);

endmodule

// File: tb/tb_qpsk_carrier_mod.sv
`timescale 1ns/1ps
module tb_qpsk_carrier_mod;
  localparam int SAMP_W  = 8;
  localparam int PH_W    = 6;
  localparam int PERIODS = 2;
  localparam int DEPTH   = 1 << PH_W;
  localparam int SLOT    = DEPTH * PERIODS;
  localparam int AMP     = (1 << (SAMP_W - 1)) - 1;
  localparam int TOL     = 3;
  localparam int LAST_SLOT = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_int = 1'b0;
  logic bit_in = 1'b0;
  logic bit_valid = 1'b0;
  logic signed [SAMP_W:0] sample_out;
  logic sample_valid;

  always #2.5 clk = ~clk;

  qpsk_carrier_mod #(.SAMP_W(SAMP_W), .PH_W(PH_W), .PERIODS_PER_SYM(PERIODS)) dut (
    .clk(clk), .rst(rst), .src_int(src_int), .bit_in(bit_in),
    .bit_valid(bit_valid), .sample_out(sample_out), .sample_valid(sample_valid)
  );

  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    bit    i;
    bit    q;
    bit    hold;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  logic [6:0] lf_model = 7'h01;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int carrier(input int p, input bit is_cos, input bit pos);
    real ang;
    int  v;
    ang = 2.0 * 3.14159265358979 * p / DEPTH;
    v   = is_cos ? int'(AMP * $cos(ang)) : int'(AMP * $sin(ang));
    return pos ? v : -v;
  endfunction

  function automatic int expected(input int g, input bit i, input bit q);
    int p;
    p = g % DEPTH;
    return carrier(p, 1'b1, i) + carrier(p, 1'b0, q);
  endfunction

  function automatic bit model_bit();
    bit b;
    b = lf_model[6];
    lf_model = {lf_model[5:0], lf_model[6] ^ lf_model[5]};
    return b;
  endfunction

  task automatic wait_offset();
    do @(negedge clk); while ((cyc % SLOT) != 10);
  endtask

  // Driver: sends one pair early in the current slot and queues what the next slot must show.
  task automatic send_pair(input bit use_int, input bit i, input bit q, input string tag);
    exp_t e;
    bit b1;
    bit b2;
    wait_offset();
    if (use_int) begin
      b1 = model_bit();
      b2 = model_bit();
    end else begin
      b1 = i;
      b2 = q;
    end
    e.i = b1; e.q = b2; e.hold = 1'b0; e.tag = tag;
    exp_q.push_back(e);
    src_int   = use_int;
    bit_valid = 1'b1;
    bit_in    = use_int ? ~b1 : b1;
    @(negedge clk);
    bit_in    = use_int ? ~b2 : b2;
    @(negedge clk);
    bit_valid = 1'b0;
    bit_in    = 1'b0;
  endtask

  task automatic idle_slot();
    exp_t e;
    wait_offset();
    e.i = 1'b0; e.q = 1'b0; e.hold = 1'b1; e.tag = "R5";
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Monitor: pops the expectation at each slot start and compares every sample.
  initial begin : monitor
    bit    cur_i = 1'b0;
    bit    cur_q = 1'b0;
    string cur_tag = "R1";
    int    mism = 0;
    int    ovf = 0;
    int    bad_act = 0;
    int    bad_exp = 0;
    forever begin
      @(negedge clk);
      if (!rst && !done && cyc >= 2) begin
        int g;
        int ev;
        int sv;
        g = cyc - 2;
        if ((g % SLOT) == 0 && g >= SLOT) begin
          if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            if (!e.hold) begin
              cur_i = e.i;
              cur_q = e.q;
            end
            cur_tag = e.tag;
          end else begin
            cur_tag = "R5";
          end
        end
        sv = int'(sample_out);
        ev = expected(g, cur_i, cur_q);
        if ((sv - ev > TOL) || (ev - sv > TOL)) begin
          if (mism == 0) begin
            bad_act = sv;
            bad_exp = ev;
          end
          mism++;
        end
        if (sv > 2 * AMP || sv < -2 * AMP) ovf++;
        if (g == SLOT - 1) begin
          check(sample_valid == 1'b0, "R6", "valid before first pair", int'(sample_valid), 0);
          check(sv - expected(g, 1'b0, 1'b0) <= TOL && expected(g, 1'b0, 1'b0) - sv <= TOL,
                "R3", "last sample of slot 0 still uses reset selects", sv, expected(g, 1'b0, 1'b0));
        end
        if (g == SLOT) begin
          check(sample_valid == 1'b1, "R6", "valid at first loaded sample", int'(sample_valid), 1);
          check(sv - expected(g, 1'b1, 1'b1) <= TOL && expected(g, 1'b1, 1'b1) - sv <= TOL,
                "R3", "first sample of slot 1 uses pair from slot 0", sv, expected(g, 1'b1, 1'b1));
        end
        if ((g % SLOT) == SLOT - 1) begin
          check(mism == 0, cur_tag, $sformatf("slot %0d sample mismatch", g / SLOT), bad_act, bad_exp);
          check(ovf == 0, "R8", $sformatf("slot %0d samples within range", g / SLOT), ovf, 0);
          mism = 0;
          ovf  = 0;
        end
      end
    end
  end

  initial begin : main
    repeat (5) @(negedge clk);
    check(sample_out == '0 && sample_valid == 1'b0, "R1", "outputs during reset",
          int'(sample_out) + int'(sample_valid), 0);
    rst = 1'b0;
    send_pair(1'b0, 1'b1, 1'b1, "R4");
    send_pair(1'b0, 1'b0, 1'b1, "R2");
    send_pair(1'b0, 1'b0, 1'b0, "R4");
    send_pair(1'b0, 1'b1, 1'b0, "R2");
    idle_slot();
    send_pair(1'b1, 1'b0, 1'b0, "R7");
    send_pair(1'b1, 1'b0, 1'b0, "R7");
    send_pair(1'b1, 1'b0, 1'b0, "R7");
    send_pair(1'b0, 1'b1, 1'b1, "R4");
    idle_slot();
    while (cyc < LAST_SLOT * SLOT + 2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, LAST_SLOT * SLOT + 2);
      finish_run();
    end
  end

endmodule